// File: doc/BRIEF.md
# Maskable Event Interrupt Priority Arbiter

This block selects one of nine maskable peripheral event interrupt requests and presents it to a processor core. Each source has a 3-bit priority field. A field of zero turns the source off. A nonzero field value n is promoted to the effective 4-bit priority 8+n. Because of this, every event source sits in the upper half of the core's 4-bit priority space. One global enable and one enable per source gate the requests. The highest effective priority wins. Among equal priorities, the source with the lowest index wins. The winner is forwarded only if its priority is strictly above the core's current execution priority.

Each source is either edge-type or level-type. An edge-type source latches a rising edge of its request line as a pending flag. That flag stays set until the core acknowledges the source as the winner. A level-type source is pending only while its input is high, and acknowledge has no effect on it. The winner index, its effective priority and the request to the core are all registered, so they stay steady for the full cycle in which the core samples them.

Top module: `evt_irq_arb`

## Requirements
- R1: While reset is asserted and right after it, `irq_o` is 0, `win_idx_o` is 0 and `win_prio_o` is 0, whatever the inputs are.
- R2: A source whose field value n is in 1..7 reports an effective priority of 8+n on `win_prio_o` when it wins. Source i's field is bits [3i+2:3i] of `prio_i`.
- R3: A source whose field is 0 never wins. `win_prio_o` only ever holds 0 or a value of 8 or more.
- R4: While `glb_en_i` is 0, no source is eligible and `irq_o` is 0.
- R5: A source whose bit in `src_en_i` is 0 is ignored, and a lower-priority enabled source can win instead.
- R6: Among the eligible sources, the one with the highest effective priority wins.
- R7: When several eligible sources share the highest effective priority, the one with the lowest index wins.
- R8: `win_idx_o` and `win_prio_o` always report the best eligible source. `irq_o` is 1 only when that source's priority is strictly greater than `core_prio_i`. An equal core priority blocks the request.
- R9: A source marked 1 in `edge_mode_i` latches a rising edge of its request line. A one-cycle pulse therefore stays pending until it is acknowledged.
- R10: A one-cycle `ack_i` pulse while `irq_o` is 1 clears the pending flag of the edge-type winner. A request line still held high does not set the flag again. `ack_i` while `irq_o` is 0 leaves every pending flag untouched.
- R11: A level-type source is pending exactly while its input is high, and `ack_i` does not affect it.
- R12: The outputs are registered. A level-type request driven before a rising edge shows on `irq_o` after that edge. An edge-type request shows after the following edge, because its edge is latched first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 9 | Request line per source |
| edge_mode_i | input | 9 | 1 = edge-type source, 0 = level-type |
| glb_en_i | input | 1 | Global enable for all event sources |
| src_en_i | input | 9 | Enable per source |
| prio_i | input | 27 | Packed 3-bit priority fields, source i in bits [3i+2:3i] |
| core_prio_i | input | 4 | Current execution priority of the core |
| ack_i | input | 1 | Acknowledge of the presented request |
| irq_o | output | 1 | Interrupt request to the core |
| win_idx_o | output | 4 | Index of the winning source |
| win_prio_o | output | 4 | Effective priority of the winning source |

## Verification
The bench sets up equal priorities across scattered indices, a winner whose priority equals the core priority, and zero-valued fields mixed with active ones. A design with a reversed tie rule, a non-strict compare, or a missing promotion to 8+n would report a wrong index or priority, or raise a request the core must not see. For edge-type sources, the bench acknowledges while the request line is still high. A design that re-detects the level would then raise the request again. The bench also acknowledges while the request is blocked by the core priority. A design that clears on a bare acknowledge would lose that request. The bench also samples the exact cycle when a level-type and an edge-type request first appear, so any extra or missing register stage shows up as a shifted response.

// File: rtl/evt_irq_arb.sv
module evt_irq_arb #(
  parameter int N_SRC = 9,
  parameter int FW    = 3,
  localparam int IW   = $clog2(N_SRC),
  localparam int PW   = FW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  req_i,
  input  logic [N_SRC-1:0]  edge_mode_i,
  input  logic              glb_en_i,
  input  logic [N_SRC-1:0]  src_en_i,
  input  logic [N_SRC*FW-1:0] prio_i,
  input  logic [PW-1:0]     core_prio_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [IW-1:0]     win_idx_o,
  output logic [PW-1:0]     win_prio_o
);

  logic [N_SRC-1:0] req_q, pend_q, active, elig;
  logic [PW-1:0]    eff [N_SRC];
  logic             best_v;
  logic [IW-1:0]    best_i;
  logic [PW-1:0]    best_p;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    wire [FW-1:0] fld = prio_i[g*FW +: FW];
    assign eff[g]    = (fld == '0) ? '0 : {1'b1, fld};
    assign active[g] = edge_mode_i[g] ? pend_q[g] : req_i[g];
    assign elig[g]   = glb_en_i & src_en_i[g] & active[g] & (fld != '0);
  end

  always_comb begin
    best_v = 1'b0;
    best_i = '0;
    best_p = '0;
    for (int i = 0; i < N_SRC; i++)
      if (elig[i] && (!best_v || eff[i] > best_p)) begin
        best_v = 1'b1;
        best_i = IW'(i);
        best_p = eff[i];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q <= req_i;
      for (int i = 0; i < N_SRC; i++) begin
        if (!edge_mode_i[i])
          pend_q[i] <= 1'b0;
        else if (req_i[i] && !req_q[i])
          pend_q[i] <= 1'b1;
        else if (ack_i && irq_o && win_idx_o == IW'(i))
          pend_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o      <= 1'b0;
      win_idx_o  <= '0;
      win_prio_o <= '0;
    end else begin
      irq_o      <= best_v && (best_p > core_prio_i);
      win_idx_o  <= best_i;
      win_prio_o <= best_p;
    end
  end

endmodule

// File: rtl/evt_irq_arb_chk.sv
module evt_irq_arb_chk #(
  parameter int N_SRC = 9,
  parameter int FW    = 3,
  localparam int IW   = $clog2(N_SRC),
  localparam int PW   = FW + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glb_en_i,
  input logic [N_SRC-1:0] src_en_i,
  input logic [PW-1:0]    core_prio_i,
  input logic             irq_o,
  input logic [IW-1:0]    win_idx_o,
  input logic [PW-1:0]    win_prio_o
);

  logic [N_SRC-1:0] en_q;
  logic [PW-1:0]    core_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      core_q <= '0;
    end else begin
      en_q   <= src_en_i;
      core_q <= core_prio_i;
    end
  end

  assert_prio_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> win_prio_o[PW-1]);

  assert_no_low_prio_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_prio_o != '0) |-> win_prio_o[PW-1]);

  assert_glb_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(glb_en_i) |-> !irq_o);

  assert_src_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> en_q[win_idx_o]);

  assert_above_core_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (win_prio_o > core_q));

endmodule

bind evt_irq_arb evt_irq_arb_chk #(.N_SRC(N_SRC), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en_i(glb_en_i), .src_en_i(src_en_i),
  .core_prio_i(core_prio_i), .irq_o(irq_o), .win_idx_o(win_idx_o),
  .win_prio_o(win_prio_o)
);

// File: tb/evt_irq_arb_tb.sv
module evt_irq_arb_tb;
  localparam int N = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0, edge_m = '0, src_en = '1;
  logic         glb_en = 1'b1, ack = 1'b0;
  logic [N*3-1:0] prio = '0;
  logic [3:0]   core = '0;
  logic         irq;
  logic [3:0]   idx, wprio;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evt_irq_arb u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .edge_mode_i(edge_m),
    .glb_en_i(glb_en), .src_en_i(src_en), .prio_i(prio), .core_prio_i(core),
    .ack_i(ack), .irq_o(irq), .win_idx_o(idx), .win_prio_o(wprio)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string r, logic e_irq, int e_idx, int e_prio);
    n_chk++;
    if (irq !== e_irq || int'(idx) != e_idx || int'(wprio) != e_prio) begin
      n_bad++;
      $display("FAIL %s: got irq=%0b idx=%0d prio=%0d, expected irq=%0b idx=%0d prio=%0d",
               r, irq, idx, wprio, e_irq, e_idx, e_prio);
    end
  endtask

  task automatic setp(int s, int v);
    prio[s*3 +: 3] = 3'(v);
  endtask

  task automatic restart();
    req = '0; edge_m = '0; src_en = '1; glb_en = 1'b1; ack = 1'b0;
    prio = '0; core = '0;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req = '1; prio = '1;
    tick(3);
    chk("R1 in reset", 0, 0, 0);
    restart();
    chk("R1 after reset", 0, 0, 0);
  endtask

  task automatic t_map();
    restart();
    req[3] = 1; setp(3, 5);
    tick(2);
    chk("R2 src3 field5", 1, 3, 13);
    restart();
    req[0] = 1;
    for (int n = 1; n < 8; n++) begin
      setp(0, n);
      tick(2);
      chk("R2 field sweep", 1, 0, 8 + n);
    end
  endtask

  task automatic t_zero();
    restart();
    req[2] = 1; setp(2, 0);
    tick(2);
    chk("R3 zero field alone", 0, 0, 0);
    req[4] = 1; setp(4, 1);
    tick(2);
    chk("R3 zero field skipped", 1, 4, 9);
  endtask

  task automatic t_glb();
    restart();
    req[1] = 1; setp(1, 6); glb_en = 0;
    tick(2);
    chk("R4 global off", 0, 0, 0);
    glb_en = 1;
    tick(2);
    chk("R4 global on", 1, 1, 14);
  endtask

  task automatic t_src_en();
    restart();
    req[1] = 1; setp(1, 7); src_en[1] = 0;
    req[6] = 1; setp(6, 2);
    tick(2);
    chk("R5 disabled source ignored", 1, 6, 10);
  endtask

  task automatic t_highest();
    restart();
    req[0] = 1; setp(0, 2);
    req[8] = 1; setp(8, 6);
    req[4] = 1; setp(4, 5);
    tick(2);
    chk("R6 highest wins", 1, 8, 14);
  endtask

  task automatic t_tie();
    restart();
    req[7] = 1; setp(7, 4);
    req[5] = 1; setp(5, 4);
    req[3] = 1; setp(3, 4);
    tick(2);
    chk("R7 tie lowest index", 1, 3, 12);
    req[3] = 0;
    tick(2);
    chk("R7 tie after drop", 1, 5, 12);
  endtask

  task automatic t_core();
    restart();
    req[0] = 1; setp(0, 3); core = 11;
    tick(2);
    chk("R8 equal core blocks", 0, 0, 11);
    core = 10;
    tick(2);
    chk("R8 lower core passes", 1, 0, 11);
    core = 15;
    tick(2);
    chk("R8 high core blocks", 0, 0, 11);
  endtask

  task automatic t_edge();
    restart();
    edge_m[4] = 1; setp(4, 1);
    req[4] = 1;
    tick(1);
    req[4] = 0;
    tick(5);
    chk("R9 pulse stays pending", 1, 4, 9);
  endtask

  task automatic t_ack();
    restart();
    edge_m[2] = 1; setp(2, 3);
    req[2] = 1;
    tick(3);
    chk("R10 edge pending", 1, 2, 11);
    ack = 1; tick(1); ack = 0;
    tick(2);
    chk("R10 ack clears with line held", 0, 0, 0);
    restart();
    edge_m[2] = 1; setp(2, 3); core = 12;
    req[2] = 1; tick(1); req[2] = 0;
    tick(2);
    ack = 1; tick(1); ack = 0;
    core = 0;
    tick(2);
    chk("R10 ack without irq keeps pending", 1, 2, 11);
  endtask

  task automatic t_level_ack();
    restart();
    req[6] = 1; setp(6, 7);
    tick(2);
    ack = 1; tick(1); ack = 0;
    tick(2);
    chk("R11 level unaffected by ack", 1, 6, 15);
    req[6] = 0;
    tick(2);
    chk("R11 level drops with input", 0, 0, 0);
  endtask

  task automatic t_latency();
    restart();
    setp(1, 2);
    req[1] = 1;
    tick(1);
    chk("R12 level after one edge", 1, 1, 10);
    restart();
    edge_m[1] = 1; setp(1, 2);
    req[1] = 1;
    tick(1);
    chk("R12 edge not yet", 0, 0, 0);
    tick(1);
    chk("R12 edge after two edges", 1, 1, 10);
  endtask

  initial begin
    tick(2);
    t_reset();
    t_map();
    t_zero();
    t_glb();
    t_src_en();
    t_highest();
    t_tie();
    t_core();
    t_edge();
    t_ack();
    t_level_ack();
    t_latency();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule